// File: doc/BRIEF.md
# Petri Net Token Engine

This block executes an ordinary Petri net in hardware. The net has at most `NP` places and `NT` transitions. Each transition is configured with two 0/1 rows. The pre row marks the places it consumes from. The post row marks the places it deposits into. Each place holds a small saturating token counter and a configurable bound. Every cycle the engine derives, combinationally from the current marking, which transitions may fire. It also raises a dead flag when none can fire.

A supervisor observes an event, then asks the engine to fire the matching transition. If the transition is enabled, the whole marking moves in one atomic update: each place loses one token per input arc and gains one per output arc. A request for a transition that is not enabled gets an error pulse and leaves the marking alone. Any firing that would take a place past its bound latches a sticky overflow flag.

The controller has four states:
- `ST_READY`: accepts configuration writes and fire requests.
- `ST_EVAL`: judges the latched transition. An enabled transition commits and moves to `ST_ACK`. A transition that is not enabled moves to `ST_NACK`.
- `ST_ACK`: pulses `fire_ok` for one cycle.
- `ST_NACK`: pulses `fire_err` for one cycle.

Both `ST_ACK` and `ST_NACK` return to `ST_READY`.

Top module: `pn_token_engine`

## Requirements
- R1: After reset the engine is in `ST_READY` (`ready`=1). Every counter is 0 and every bound is 15. All arcs are absent and `overflow`=0. Because every transition then has no input place, `enabled` is all ones and `dead`=0.
- R2: `enabled[t]` is 1 exactly when every place p with a pre arc from transition t (bit p of its pre row set) holds at least one token. A transition with an empty pre row (a source) is always enabled.
- R3: `dead` is 1 exactly when `enabled` is all zeros. A request made while dead is rejected.
- R4: Suppose a request for transition t is sampled at clock edge k and t is enabled. Then, after edge k+1, `fire_ok` is high for exactly one cycle. In that same cycle every place reads tokens − pre + post, updated at once.
- R5: Suppose a request for a transition that is not enabled is sampled at edge k. Then `fire_err` is high for exactly one cycle after edge k+1, and the marking is unchanged.
- R6: Two special cases of firing. A sink (empty post row) only removes tokens. A self-loop (a place on both the pre and post row) needs a token to fire and leaves that place's count unchanged.
- R7: A counter that would exceed 15 holds at 15. A firing whose result for any place exceeds that place's bound sets `overflow`, which stays set until reset. Bound 1 makes a place safe, so a second token overflows it.
- R8: From the edge that accepts a request until the engine returns to `ST_READY`, `ready` is 0. Fire requests and configuration writes presented during that time have no effect.
- R9: Configuration is accepted only in `ST_READY`. `cfg_arc_we` writes both arc rows of transition `cfg_tidx`. `cfg_place_we` writes the counter and bound of place `cfg_pidx`. A configuration write presented in the same cycle as an accepted fire request is dropped, and the firing proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_arc_we | input | 1 | Write arc rows of one transition |
| cfg_tidx | input | TW | Transition selected by an arc write |
| cfg_pre | input | NP | Pre row (bit p: arc from place p) |
| cfg_post | input | NP | Post row (bit p: arc into place p) |
| cfg_place_we | input | 1 | Write counter and bound of one place |
| cfg_pidx | input | PW | Place selected by a place write |
| cfg_tokens | input | CW | Token count to load |
| cfg_bound | input | CW | Bound to load |
| fire_req | input | 1 | Request to fire a transition |
| fire_idx | input | TW | Transition to fire |
| ready | output | 1 | Engine in `ST_READY` |
| fire_ok | output | 1 | One-cycle pulse: firing committed |
| fire_err | output | 1 | One-cycle pulse: request rejected |
| enabled | output | NT | Enabled transitions, bit per transition |
| dead | output | 1 | No transition enabled |
| overflow | output | 1 | Sticky bound violation |
| marking | output | NP*CW | Token counts, place p at bits p*CW+:CW |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a configuration write and an accepted fire request. The bench raises `cfg_place_we` on the same edge as `fire_req`, once in `ST_READY` and once while the engine is in `ST_EVAL`. It then checks at the ports that the firing result is correct and that the written place still holds its old count. The second pair is saturation and overflow, which meet in a single firing that pushes a full place past 15. There the bench expects the count to hold at 15 with `overflow` set. A long pseudo-random sweep of arcs, counters and requests is compared against an arithmetic model of the net.

// File: rtl/pn_pkg.sv
package pn_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_EVAL  = 2'd1,
        ST_ACK   = 2'd2,
        ST_NACK  = 2'd3
    } pn_state_e;

endpackage

// File: rtl/pn_enable_logic.sv
module pn_enable_logic #(
    parameter int NP = 8,
    parameter int NT = 8,
    parameter int CW = 4
) (
    input  logic [NP*CW-1:0] tok_flat,
    input  logic [NT*NP-1:0] pre_flat,
    output logic [NT-1:0]    en
);

    logic [NP-1:0] occupied;

    for (genvar p = 0; p < NP; p++) begin : g_occ
        assign occupied[p] = |tok_flat[p*CW +: CW];
    end

    // A place without an arc to t never blocks it; a source has no arcs at all.
    for (genvar t = 0; t < NT; t++) begin : g_en
        assign en[t] = &(occupied | ~pre_flat[t*NP +: NP]);
    end

endmodule

// File: rtl/pn_fire_update.sv
module pn_fire_update #(
    parameter int NP = 8,
    parameter int CW = 4
) (
    input  logic [NP*CW-1:0] tok_flat,
    input  logic [NP*CW-1:0] bound_flat,
    input  logic [NP-1:0]    pre_row,
    input  logic [NP-1:0]    post_row,
    output logic [NP*CW-1:0] next_flat,
    output logic             ovf_any
);

    logic [NP-1:0] ovf_vec;

    for (genvar p = 0; p < NP; p++) begin : g_place
        logic [CW:0] sum;
        always_comb begin
            sum = {1'b0, tok_flat[p*CW +: CW]}
                - {{CW{1'b0}}, pre_row[p]}
                + {{CW{1'b0}}, post_row[p]};
        end
        assign next_flat[p*CW +: CW] = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
        assign ovf_vec[p] = (sum > {1'b0, bound_flat[p*CW +: CW]});
    end

    assign ovf_any = |ovf_vec;

endmodule

// File: rtl/pn_ctrl_fsm.sv
module pn_ctrl_fsm
    import pn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    input  logic sel_en,
    output logic ready,
    output logic take_req,
    output logic commit,
    output logic fire_ok,
    output logic fire_err
);

    pn_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (fire_req) state_d = ST_EVAL;
            ST_EVAL:  state_d = sel_en ? ST_ACK : ST_NACK;
            ST_ACK:   state_d = ST_READY;
            ST_NACK:  state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    always_comb begin
        ready    = 1'b0;
        take_req = 1'b0;
        commit   = 1'b0;
        fire_ok  = 1'b0;
        fire_err = 1'b0;
        unique case (state_q)
            ST_READY: begin
                ready    = 1'b1;
                take_req = fire_req;
            end
            ST_EVAL:  commit   = sel_en;
            ST_ACK:   fire_ok  = 1'b1;
            ST_NACK:  fire_err = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/pn_token_engine.sv
module pn_token_engine #(
    parameter  int NP = 8,
    parameter  int NT = 8,
    parameter  int CW = 4,
    localparam int PW = $clog2(NP),
    localparam int TW = $clog2(NT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_arc_we,
    input  logic [TW-1:0]    cfg_tidx,
    input  logic [NP-1:0]    cfg_pre,
    input  logic [NP-1:0]    cfg_post,
    input  logic             cfg_place_we,
    input  logic [PW-1:0]    cfg_pidx,
    input  logic [CW-1:0]    cfg_tokens,
    input  logic [CW-1:0]    cfg_bound,
    input  logic             fire_req,
    input  logic [TW-1:0]    fire_idx,
    output logic             ready,
    output logic             fire_ok,
    output logic             fire_err,
    output logic [NT-1:0]    enabled,
    output logic             dead,
    output logic             overflow,
    output logic [NP*CW-1:0] marking
);

    logic [NP*CW-1:0] tok_q, bound_q, tok_next;
    logic [NT*NP-1:0] pre_q, post_q;
    logic [TW-1:0]    idx_q;
    logic             ovf_q, ovf_hit;
    logic             take_req, commit, cfg_open;

    pn_enable_logic #(.NP(NP), .NT(NT), .CW(CW)) u_enable (
        .tok_flat (tok_q),
        .pre_flat (pre_q),
        .en       (enabled)
    );

    pn_fire_update #(.NP(NP), .CW(CW)) u_update (
        .tok_flat   (tok_q),
        .bound_flat (bound_q),
        .pre_row    (pre_q[idx_q*NP +: NP]),
        .post_row   (post_q[idx_q*NP +: NP]),
        .next_flat  (tok_next),
        .ovf_any    (ovf_hit)
    );

    pn_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_req (fire_req),
        .sel_en   (enabled[idx_q]),
        .ready    (ready),
        .take_req (take_req),
        .commit   (commit),
        .fire_ok  (fire_ok),
        .fire_err (fire_err)
    );

    // Configuration only in the idle state and never alongside a request.
    assign cfg_open = ready && !fire_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q   <= '0;
            bound_q <= '1;
            pre_q   <= '0;
            post_q  <= '0;
            idx_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (take_req) idx_q <= fire_idx;
            if (commit) begin
                tok_q <= tok_next;
                if (ovf_hit) ovf_q <= 1'b1;
            end
            if (cfg_open && cfg_arc_we) begin
                pre_q[cfg_tidx*NP +: NP]  <= cfg_pre;
                post_q[cfg_tidx*NP +: NP] <= cfg_post;
            end
            if (cfg_open && cfg_place_we) begin
                tok_q[cfg_pidx*CW +: CW]   <= cfg_tokens;
                bound_q[cfg_pidx*CW +: CW] <= cfg_bound;
            end
        end
    end

    assign dead     = ~|enabled;
    assign overflow = ovf_q;
    assign marking  = tok_q;

endmodule

// File: rtl/pn_engine_checker.sv
module pn_engine_checker #(
    parameter int NP = 8,
    parameter int CW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fire_req,
    input logic             ready,
    input logic             fire_ok,
    input logic             fire_err,
    input logic             dead,
    input logic             overflow,
    input logic [NP*CW-1:0] marking
);

    p_ok_needs_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_ok |-> !$past(dead));

    p_single_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fire_ok, fire_err}));

    p_ok_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_ok |=> !fire_ok);

    p_err_keeps_marking_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_err |-> marking == $past(marking));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fire_req) |=> !ready);

    p_result_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_ok || fire_err) |-> !ready);

endmodule

bind pn_token_engine pn_engine_checker #(.NP(NP), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_req (fire_req),
    .ready    (ready),
    .fire_ok  (fire_ok),
    .fire_err (fire_err),
    .dead     (dead),
    .overflow (overflow),
    .marking  (marking)
);

// File: tb/tb_pn_token_engine.sv
`timescale 1ns/1ps
module tb_pn_token_engine;

    localparam int NP = 8;
    localparam int NT = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_arc_we, cfg_place_we, fire_req;
    logic [2:0]    cfg_tidx, cfg_pidx, fire_idx;
    logic [7:0]    cfg_pre, cfg_post;
    logic [3:0]    cfg_tokens, cfg_bound;
    logic          ready, fire_ok, fire_err, dead, overflow;
    logic [7:0]    enabled;
    logic [31:0]   marking;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int         m_tok [NP];
    int         m_bnd [NP];
    logic [7:0] m_pre [NT];
    logic [7:0] m_post[NT];
    bit         m_ovf;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    pn_token_engine #(.NP(NP), .NT(NT), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_arc_we(cfg_arc_we), .cfg_tidx(cfg_tidx), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .cfg_place_we(cfg_place_we), .cfg_pidx(cfg_pidx), .cfg_tokens(cfg_tokens), .cfg_bound(cfg_bound),
        .fire_req(fire_req), .fire_idx(fire_idx),
        .ready(ready), .fire_ok(fire_ok), .fire_err(fire_err),
        .enabled(enabled), .dead(dead), .overflow(overflow), .marking(marking)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_en();
        logic [7:0] occ, r;
        for (int p = 0; p < NP; p++) occ[p] = (m_tok[p] != 0);
        for (int t = 0; t < NT; t++) r[t] = ((m_pre[t] & ~occ) == 8'h00);
        return r;
    endfunction

    task automatic check_all(input string req);
        logic [7:0] e;
        e = exp_en();
        for (int p = 0; p < NP; p++) chk(req, $sformatf("marking[%0d]", p), int'(marking[p*4 +: 4]), m_tok[p]);
        chk(req, "enabled", int'(enabled), int'(e));
        chk(req, "dead", int'(dead), int'(e == 8'h00));
        chk(req, "overflow", int'(overflow), int'(m_ovf));
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_arc_we = 0; cfg_place_we = 0; fire_req = 0;
        cfg_tidx = 0; cfg_pidx = 0; fire_idx = 0; cfg_pre = 0; cfg_post = 0;
        cfg_tokens = 0; cfg_bound = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < NP; p++) begin m_tok[p] = 0; m_bnd[p] = 15; end
        for (int t = 0; t < NT; t++) begin m_pre[t] = 0; m_post[t] = 0; end
        m_ovf = 0;
        @(negedge clk);
    endtask

    task automatic set_arc(input int t, input logic [7:0] pre, input logic [7:0] post);
        cfg_arc_we = 1; cfg_tidx = 3'(t); cfg_pre = pre; cfg_post = post;
        @(negedge clk);
        cfg_arc_we = 0;
        m_pre[t] = pre; m_post[t] = post;
    endtask

    task automatic set_place(input int p, input int tok, input int bnd);
        cfg_place_we = 1; cfg_pidx = 3'(p); cfg_tokens = 4'(tok); cfg_bound = 4'(bnd);
        @(negedge clk);
        cfg_place_we = 0;
        m_tok[p] = tok; m_bnd[p] = bnd;
    endtask

    task automatic model_fire(input int t);
        for (int p = 0; p < NP; p++) begin
            int s;
            s = m_tok[p] - int'(m_pre[t][p]) + int'(m_post[t][p]);
            if (s > m_bnd[p]) m_ovf = 1;
            m_tok[p] = (s > 15) ? 15 : s;
        end
    endtask

    // Request sampled at edge k; result visible after edge k+1 (R4/R5).
    task automatic do_fire(input int t, input string req);
        bit ok;
        ok = exp_en()[t];
        fire_req = 1; fire_idx = 3'(t);
        @(negedge clk);
        fire_req = 0;
        chk(req, "ready while evaluating", int'(ready), 0);
        @(negedge clk);
        chk(req, "fire_ok", int'(fire_ok), int'(ok));
        chk(req, "fire_err", int'(fire_err), int'(!ok));
        if (ok) model_fire(t);
        check_all(req);
        @(negedge clk);
        chk(req, "ready after result", int'(ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats[4];
        pats[0] = 8'hA5; pats[1] = 8'h0F; pats[2] = 8'hFF; pats[3] = 8'h00;

        // R1 reset state
        do_reset();
        chk("R1", "ready", int'(ready), 1);
        chk("R1", "fire_ok", int'(fire_ok), 0);
        check_all("R1");

        // R2 exhaustive pre-row sweep on transition 0 under several markings
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < NP; p++) set_place(p, pats[k][p] ? (p % 3) + 1 : 0, 15);
            for (int m = 0; m < 256; m++) begin
                set_arc(0, 8'(m), 8'h00);
                chk("R2", "enabled[0]", int'(enabled[0]), int'((8'(m) & ~pats[k]) == 8'h00));
                chk("R3", "dead", int'(dead), 0);
            end
        end

        // R6 source, sink, self-loop; R5 rejections
        do_reset();
        set_arc(0, 8'h00, 8'h01);
        set_arc(1, 8'h01, 8'h00);
        set_arc(2, 8'h02, 8'h02);
        do_fire(2, "R5");
        set_place(1, 1, 15);
        do_fire(2, "R6");
        do_fire(0, "R6");
        do_fire(1, "R6");
        do_fire(1, "R5");

        // R3 dead net rejects everything
        for (int t = 0; t < NT; t++) set_arc(t, 8'h01, 8'h02);
        set_place(0, 0, 15);
        check_all("R3");
        chk("R3", "dead high", int'(dead), 1);
        do_fire(4, "R3");

        // R7 safe place overflows, then saturation at 15 with overflow
        do_reset();
        set_place(2, 1, 1);
        set_arc(3, 8'h00, 8'h04);
        do_fire(3, "R7");
        chk("R7", "safe overflow", int'(overflow), 1);
        do_reset();
        set_place(3, 15, 15);
        set_arc(4, 8'h00, 8'h08);
        do_fire(4, "R7");
        chk("R7", "saturated", int'(marking[12 +: 4]), 15);
        do_fire(5, "R7");
        chk("R7", "sticky", int'(overflow), 1);

        // R8 request and config presented while busy are ignored
        do_reset();
        set_arc(0, 8'h00, 8'h01);
        fire_req = 1; fire_idx = 0;
        @(negedge clk);
        cfg_place_we = 1; cfg_pidx = 5; cfg_tokens = 9; cfg_bound = 15;
        chk("R8", "ready low", int'(ready), 0);
        @(negedge clk);
        fire_req = 0; cfg_place_we = 0;
        chk("R8", "fire_ok", int'(fire_ok), 1);
        model_fire(0);
        check_all("R8");
        @(negedge clk);
        chk("R8", "no second result", int'(fire_ok | fire_err), 0);
        @(negedge clk);
        check_all("R8");

        // R9 config write in the same cycle as an accepted request is dropped
        fire_req = 1; fire_idx = 0;
        cfg_place_we = 1; cfg_pidx = 5; cfg_tokens = 9; cfg_bound = 15;
        @(negedge clk);
        fire_req = 0; cfg_place_we = 0;
        @(negedge clk);
        chk("R9", "fire_ok", int'(fire_ok), 1);
        model_fire(0);
        check_all("R9");
        @(negedge clk);
        set_place(6, 7, 9);
        check_all("R9");

        // R4 pseudo-random sweep against the model
        do_reset();
        for (int i = 0; i < 600; i++) begin
            step_lfsr();
            if (lfsr[1:0] == 2'b00) begin
                logic [7:0] a;
                a = lfsr[15:8];
                step_lfsr();
                set_arc(int'(lfsr[4:2]), a & lfsr[15:8], lfsr[12:5]);
            end else if (lfsr[1:0] == 2'b01) begin
                set_place(int'(lfsr[4:2]), int'(lfsr[8:5]) % 4, 15);
            end
            step_lfsr();
            do_fire(int'(lfsr[2:0]), "R4");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule